// File: doc/BRIEF.md
# Dual-clock FIFO with programmable flags

This block is an 18-bit first-in first-out buffer whose depth is a parameter (256 words by default, up to 4096). The write side and the read side each have their own free-running clock and an active-low enable. The two clocks may be the same net or fully unrelated. Each write pointer and read pointer crosses to the other domain as Gray code through a two-stage synchronizer. Full, almost-full and half-full are computed in the write domain. Empty and almost-empty are computed in the read domain.

The almost-empty and almost-full thresholds come from two offset registers. Both reset to 7. They can be rewritten at run time: hold the load input low and issue write-enabled cycles, and the write data bus supplies the offsets. A two-state sequencer picks the target register for each such write. An output-enable input gates the read data bus. The high-impedance state is modelled as a zeroed bus plus a separate drive-enable output.

Top module: `dcfifo_pf`

## Requirements
- R1: While `wr_en_n` is low, `load_n` is high and `full` is low, each rising `wr_clk` edge stores `wr_data`. Stored words leave the buffer in the order they were written.
- R2: While `rd_en_n` is low and `empty` is low, each rising `rd_clk` edge moves the oldest word into the output register. The word appears on `rd_data` after that edge.
- R3: A write attempted while `full` is high is ignored. The word is not stored and the write pointer does not move.
- R4: A read attempted while `empty` is high is ignored. The read pointer does not move and `rd_data` keeps its previous value.
- R5: `empty` is high when the read domain sees zero stored words. `full` is high when the write domain sees exactly DEPTH stored words.
- R6: `almost_empty` is high when the stored word count is at most the empty offset. That offset resets to 7.
- R7: `almost_full` is high when the free space (DEPTH minus the stored word count) is at most the full offset. That offset resets to 7.
- R8: `half_full` is high when the stored word count is greater than DEPTH/2.
- R9: While `load_n` is low, each cycle with `wr_en_n` low writes the low log2(DEPTH) bits of `wr_data` into an offset register, and nothing is stored in the buffer. The first such write goes to the empty offset and the second to the full offset, and later writes keep alternating. Whenever `load_n` is high, the next load write goes to the empty offset again.
- R10: While `out_en` is low, `rd_data_oe` is low and `rd_data` is all zeros. `out_en` has no effect on whether reads happen.
- R11: With `rd_clk` unrelated to `wr_clk`, every word is delivered once, unchanged and in order.
- R12: After reset, `empty` and `almost_empty` are high, `full`, `almost_full` and `half_full` are low, and the output register holds zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_en_n | input | 1 | Active-low write enable |
| load_n | input | 1 | Active-low offset load select |
| wr_data | input | 18 | Write data (also offset value during load) |
| full | output | 1 | Buffer holds DEPTH words |
| almost_full | output | 1 | Free space at or below full offset |
| half_full | output | 1 | More than DEPTH/2 words stored |
| rd_clk | input | 1 | Read-side clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_en_n | input | 1 | Active-low read enable |
| out_en | input | 1 | Output enable for the read data bus |
| rd_data | output | 18 | Read data, zero when not enabled |
| rd_data_oe | output | 1 | Drive enable for rd_data |
| empty | output | 1 | No words stored |
| almost_empty | output | 1 | Stored count at or below empty offset |

## Verification
The bench fills the buffer to exactly DEPTH words and keeps writing. A design that stored those extra words would hand back a foreign word, or lose the oldest one, during the drain that follows. It reads past empty and checks that the output register holds its last value; a design that moved its read pointer there would later return stale data. Each programmable flag is checked on both sides of its threshold, at the default offsets and after new offsets are loaded. A later load separated by a `load_n` high cycle must target the empty offset again, so a sequencer that failed to restart would move the wrong threshold. A final phase runs the read side on an unrelated clock and checks word order across the Gray-code crossing.

// File: rtl/fifo_pf_pkg.sv
`timescale 1ns/1ps
package fifo_pf_pkg;
    localparam int DATA_W      = 18;
    localparam int PTR_MAX     = 13;
    localparam int OFF_DEFAULT = 7;

    typedef logic [DATA_W-1:0]  word_t;
    typedef logic [PTR_MAX-1:0] ptr_max_t;

    typedef enum logic {
        LD_EMPTY_OFS = 1'b0,
        LD_FULL_OFS  = 1'b1
    } ld_sel_e;

    typedef struct packed {
        logic full;
        logic almost_full;
        logic half_full;
    } wr_flags_t;

    typedef struct packed {
        logic empty;
        logic almost_empty;
    } rd_flags_t;

    function automatic ptr_max_t bin2gray(input ptr_max_t b);
        return b ^ (b >> 1);
    endfunction

    function automatic ptr_max_t gray2bin(input ptr_max_t g);
        ptr_max_t b;
        b[PTR_MAX-1] = g[PTR_MAX-1];
        for (int i = PTR_MAX - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction
endpackage

// File: rtl/fifo_pf_ram.sv
`timescale 1ns/1ps
module fifo_pf_ram
    import fifo_pf_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  word_t         wdata,
    input  logic          rclk,
    input  logic          rrst,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output word_t         rdata
);
    word_t mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge rclk) begin
        if (rrst) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= mem[raddr];
        end
    end
endmodule

// File: rtl/fifo_pf_offset_loader.sv
`timescale 1ns/1ps
module fifo_pf_offset_loader
    import fifo_pf_pkg::*;
#(
    parameter int OFF_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_n,
    input  logic             wr_en_n,
    input  logic [OFF_W-1:0] din,
    output logic [OFF_W-1:0] ae_off,
    output logic [OFF_W-1:0] af_off
);
    ld_sel_e sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel    <= LD_EMPTY_OFS;
            ae_off <= OFF_W'(OFF_DEFAULT);
            af_off <= OFF_W'(OFF_DEFAULT);
        end else if (load_n) begin
            sel <= LD_EMPTY_OFS;
        end else if (!wr_en_n) begin
            if (sel == LD_EMPTY_OFS) begin
                ae_off <= din;
                sel    <= LD_FULL_OFS;
            end else begin
                af_off <= din;
                sel    <= LD_EMPTY_OFS;
            end
        end
    end
endmodule

// File: rtl/fifo_pf_wr_ctl.sv
`timescale 1ns/1ps
module fifo_pf_wr_ctl
    import fifo_pf_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int PW    = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_req,
    input  logic [PW-1:0] rgray,
    input  logic [PW-2:0] af_off,
    output logic [PW-1:0] wbin,
    output logic [PW-1:0] wgray,
    output wr_flags_t     flags,
    output logic          fire
);
    localparam logic [PW-1:0] CAP = PW'(DEPTH);

    logic [PW-1:0] rgray_m, rgray_s;
    logic [PW-1:0] rbin_s, used, room, wbin_nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            rgray_m <= '0;
            rgray_s <= '0;
        end else begin
            rgray_m <= rgray;
            rgray_s <= rgray_m;
        end
    end

    assign rbin_s = PW'(gray2bin(ptr_max_t'(rgray_s)));
    assign used   = wbin - rbin_s;
    assign room   = CAP - used;

    always_comb begin
        flags.full        = (used == CAP);
        flags.almost_full = (room <= {1'b0, af_off});
        flags.half_full   = (used > (CAP >> 1));
    end

    assign fire     = wr_req && !flags.full;
    assign wbin_nxt = wbin + PW'(fire);

    always_ff @(posedge clk) begin
        if (rst) begin
            wbin  <= '0;
            wgray <= '0;
        end else begin
            wbin  <= wbin_nxt;
            wgray <= PW'(bin2gray(ptr_max_t'(wbin_nxt)));
        end
    end
endmodule

// File: rtl/fifo_pf_rd_ctl.sv
`timescale 1ns/1ps
module fifo_pf_rd_ctl
    import fifo_pf_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int PW    = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_req,
    input  logic [PW-1:0] wgray,
    input  logic [PW-2:0] ae_off,
    output logic [PW-1:0] rbin,
    output logic [PW-1:0] rgray,
    output rd_flags_t     flags,
    output logic          fire
);
    logic [PW-1:0] wgray_m, wgray_s;
    logic [PW-1:0] wbin_s, used, rbin_nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            wgray_m <= '0;
            wgray_s <= '0;
        end else begin
            wgray_m <= wgray;
            wgray_s <= wgray_m;
        end
    end

    assign wbin_s = PW'(gray2bin(ptr_max_t'(wgray_s)));
    assign used   = wbin_s - rbin;

    always_comb begin
        flags.empty        = (used == '0);
        flags.almost_empty = (used <= {1'b0, ae_off});
    end

    assign fire     = rd_req && !flags.empty;
    assign rbin_nxt = rbin + PW'(fire);

    always_ff @(posedge clk) begin
        if (rst) begin
            rbin  <= '0;
            rgray <= '0;
        end else begin
            rbin  <= rbin_nxt;
            rgray <= PW'(bin2gray(ptr_max_t'(rbin_nxt)));
        end
    end
endmodule

// File: rtl/dcfifo_pf.sv
`timescale 1ns/1ps
module dcfifo_pf
    import fifo_pf_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic              wr_clk,
    input  logic              wr_rst,
    input  logic              wr_en_n,
    input  logic              load_n,
    input  logic [DATA_W-1:0] wr_data,
    output logic              full,
    output logic              almost_full,
    output logic              half_full,
    input  logic              rd_clk,
    input  logic              rd_rst,
    input  logic              rd_en_n,
    input  logic              out_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_data_oe,
    output logic              empty,
    output logic              almost_empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [AW-1:0] ae_off, af_off;
    logic [PW-1:0] wbin, wgray, rbin, rgray;
    wr_flags_t     wflags;
    rd_flags_t     rflags;
    logic          wr_fire, rd_fire;
    word_t         rd_q;

    fifo_pf_offset_loader #(.OFF_W(AW)) i_loader (
        .clk     (wr_clk),
        .rst     (wr_rst),
        .load_n  (load_n),
        .wr_en_n (wr_en_n),
        .din     (wr_data[AW-1:0]),
        .ae_off  (ae_off),
        .af_off  (af_off)
    );

    fifo_pf_wr_ctl #(.DEPTH(DEPTH), .PW(PW)) i_wr_ctl (
        .clk    (wr_clk),
        .rst    (wr_rst),
        .wr_req (!wr_en_n && load_n),
        .rgray  (rgray),
        .af_off (af_off),
        .wbin   (wbin),
        .wgray  (wgray),
        .flags  (wflags),
        .fire   (wr_fire)
    );

    fifo_pf_rd_ctl #(.DEPTH(DEPTH), .PW(PW)) i_rd_ctl (
        .clk    (rd_clk),
        .rst    (rd_rst),
        .rd_req (!rd_en_n),
        .wgray  (wgray),
        .ae_off (ae_off),
        .rbin   (rbin),
        .rgray  (rgray),
        .flags  (rflags),
        .fire   (rd_fire)
    );

    fifo_pf_ram #(.DEPTH(DEPTH), .AW(AW)) i_ram (
        .wclk  (wr_clk),
        .we    (wr_fire),
        .waddr (wbin[AW-1:0]),
        .wdata (wr_data),
        .rclk  (rd_clk),
        .rrst  (rd_rst),
        .re    (rd_fire),
        .raddr (rbin[AW-1:0]),
        .rdata (rd_q)
    );

    assign full         = wflags.full;
    assign almost_full  = wflags.almost_full;
    assign half_full    = wflags.half_full;
    assign empty        = rflags.empty;
    assign almost_empty = rflags.almost_empty;
    assign rd_data      = out_en ? rd_q : '0;
    assign rd_data_oe   = out_en;
endmodule

// File: rtl/fifo_pf_checker.sv
`timescale 1ns/1ps
module fifo_pf_checker #(
    parameter int PW = 9
) (
    input logic          wr_clk,
    input logic          wr_rst,
    input logic          rd_clk,
    input logic          rd_rst,
    input logic          wr_en_n,
    input logic          load_n,
    input logic          rd_en_n,
    input logic          out_en,
    input logic          full,
    input logic          half_full,
    input logic          empty,
    input logic          rd_data_oe,
    input logic [17:0]   rd_data,
    input logic [PW-1:0] wptr,
    input logic [PW-1:0] rptr
);
    assert_no_overflow_R3: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (full && !wr_en_n && load_n) |=> $stable(wptr));

    assert_no_underflow_R4: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (empty && !rd_en_n) |=> $stable(rptr));

    assert_wptr_single_step_R1: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (wptr != $past(wptr)) |-> (wptr == PW'($past(wptr) + 1'b1)));

    assert_rptr_single_step_R2: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (rptr != $past(rptr)) |-> (rptr == PW'($past(rptr) + 1'b1)));

    assert_load_bypasses_array_R9: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (!load_n && !wr_en_n) |=> $stable(wptr));

    assert_bus_gated_R10: assert property (@(posedge rd_clk) disable iff (rd_rst)
        !out_en |-> (rd_data == '0 && !rd_data_oe));

    assert_full_above_half_R8: assert property (@(posedge wr_clk) disable iff (wr_rst)
        full |-> half_full);
endmodule

bind dcfifo_pf fifo_pf_checker #(.PW(PW)) i_chk (
    .wr_clk     (wr_clk),
    .wr_rst     (wr_rst),
    .rd_clk     (rd_clk),
    .rd_rst     (rd_rst),
    .wr_en_n    (wr_en_n),
    .load_n     (load_n),
    .rd_en_n    (rd_en_n),
    .out_en     (out_en),
    .full       (full),
    .half_full  (half_full),
    .empty      (empty),
    .rd_data_oe (rd_data_oe),
    .rd_data    (rd_data),
    .wptr       (wbin),
    .rptr       (rbin)
);

// File: tb/test_dcfifo_pf.sv
`timescale 1ns/1ps
module test_dcfifo_pf;
    localparam int DEPTH = 256;

    typedef struct packed {
        int   nw;
        int   nr;
        logic e;
        logic ae;
        logic hf;
        logic af;
        logic f;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{5,   0,   1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{3,   0,   1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{0,   1,   1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{122, 0,   1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        '{0,   1,   1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{120, 0,   1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        '{1,   0,   1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
        '{7,   0,   1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
        '{2,   0,   1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
        '{0,   256, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        '{0,   3,   1'b1, 1'b1, 1'b0, 1'b0, 1'b0}
    };

    logic clk = 1'b0;
    logic aclk = 1'b0;
    logic async_mode = 1'b0;
    logic rd_clk;
    always #4 clk = ~clk;
    always #7 aclk = ~aclk;
    assign rd_clk = async_mode ? aclk : clk;

    logic        rst = 1'b1;
    logic        wr_en_n = 1'b1;
    logic        load_n = 1'b1;
    logic [17:0] wr_data = '0;
    logic        rd_en_n = 1'b1;
    logic        out_en = 1'b1;
    logic        full, almost_full, half_full, empty, almost_empty, rd_data_oe;
    logic [17:0] rd_data;

    int checks = 0;
    int errors = 0;
    int wi = 0;
    int ri = 0;
    logic [17:0] last_rd = '0;

    dcfifo_pf #(.DEPTH(DEPTH)) i_dcfifo_pf (
        .wr_clk       (clk),
        .wr_rst       (rst),
        .wr_en_n      (wr_en_n),
        .load_n       (load_n),
        .wr_data      (wr_data),
        .full         (full),
        .almost_full  (almost_full),
        .half_full    (half_full),
        .rd_clk       (rd_clk),
        .rd_rst       (rst),
        .rd_en_n      (rd_en_n),
        .out_en       (out_en),
        .rd_data      (rd_data),
        .rd_data_oe   (rd_data_oe),
        .empty        (empty),
        .almost_empty (almost_empty)
    );

    function automatic logic [17:0] pat(input int i);
        return 18'((i * 1237 + 91) ^ (i << 7));
    endfunction

    task automatic check_val(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_flags(input string tag, input logic e, input logic ae,
                               input logic hf, input logic af, input logic f);
        check_val({tag, " R5 empty"}, 32'(empty), 32'(e));
        check_val({tag, " R6 almost_empty"}, 32'(almost_empty), 32'(ae));
        check_val({tag, " R8 half_full"}, 32'(half_full), 32'(hf));
        check_val({tag, " R7 almost_full"}, 32'(almost_full), 32'(af));
        check_val({tag, " R5 full"}, 32'(full), 32'(f));
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    // R1 / R3: writes beyond DEPTH carry a foreign value and are not counted
    task automatic do_writes(input int n);
        for (int i = 0; i < n; i++) begin
            wr_en_n = 1'b0;
            if (wi - ri < DEPTH) begin
                wr_data = pat(wi);
                wi++;
            end else begin
                wr_data = 18'h2AAAA;
            end
            @(negedge clk);
        end
        wr_en_n = 1'b1;
    endtask

    // R2 / R4: data order, and hold of rd_data on reads past empty
    task automatic do_reads(input int n);
        for (int i = 0; i < n; i++) begin
            rd_en_n = 1'b0;
            if (wi - ri > 0) begin
                @(negedge clk);
                check_val("R2 read data order", 32'(rd_data), 32'(pat(ri)));
                last_rd = pat(ri);
                ri++;
            end else begin
                @(negedge clk);
                check_val("R4 read on empty holds data", 32'(rd_data), 32'(last_rd));
            end
        end
        rd_en_n = 1'b1;
    endtask

    task automatic load_word(input logic [17:0] val);
        load_n  = 1'b0;
        wr_en_n = 1'b0;
        wr_data = val;
        @(negedge clk);
        wr_en_n = 1'b1;
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12: reset state
        check_flags("R12 reset", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        check_val("R12 reset output register", 32'(rd_data), 32'h0);

        for (int v = 0; v < NV; v++) begin
            do_writes(VECS[v].nw);
            settle();
            do_reads(VECS[v].nr);
            settle();
            check_flags($sformatf("vec%0d", v), VECS[v].e, VECS[v].ae,
                        VECS[v].hf, VECS[v].af, VECS[v].f);
        end

        // R9: load empty offset 3 and full offset 2
        load_word(18'd3);
        load_word(18'd2);
        load_n = 1'b1;
        settle();
        check_flags("R9 load leaves buffer empty", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        do_writes(3);
        settle();
        check_flags("R9 three words at offset 3", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        do_writes(1);
        settle();
        check_flags("R9 four words", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        do_writes(249);
        settle();
        check_flags("R9 free three", 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        do_writes(1);
        settle();
        check_flags("R9 free two", 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        do_reads(254);
        settle();
        check_flags("R9 drained", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);

        // R9: load_n high between loads restarts at the empty offset
        load_word(18'd0);
        load_n = 1'b1;
        @(negedge clk);
        load_word(18'd20);
        load_n = 1'b1;
        settle();
        do_writes(20);
        settle();
        check_flags("R9 restart 20 words", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        do_writes(1);
        settle();
        check_flags("R9 restart 21 words", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

        // R10: output enable gates the bus but not the read itself
        out_en = 1'b0;
        #1;
        check_val("R10 bus zero when disabled", 32'(rd_data), 32'h0);
        check_val("R10 oe low when disabled", 32'(rd_data_oe), 32'h0);
        rd_en_n = 1'b0;
        @(negedge clk);
        rd_en_n = 1'b1;
        check_val("R10 bus zero during read", 32'(rd_data), 32'h0);
        out_en = 1'b1;
        #1;
        check_val("R10 read happened while disabled", 32'(rd_data), 32'(pat(ri)));
        check_val("R10 oe high when enabled", 32'(rd_data_oe), 32'h1);
        last_rd = pat(ri);
        ri++;
        @(negedge clk);
        do_reads(20);
        settle();
        check_flags("R10 drained", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);

        // R11: unrelated read clock
        async_mode = 1'b1;
        repeat (4) @(negedge aclk);
        fork
            begin : writer
                @(negedge clk);
                for (int i = 0; i < 40; i++) begin
                    wr_en_n = 1'b0;
                    wr_data = pat(wi);
                    wi++;
                    @(negedge clk);
                end
                wr_en_n = 1'b1;
            end
            begin : reader
                int   got;
                int   guard;
                logic will;
                got   = 0;
                guard = 0;
                @(negedge rd_clk);
                rd_en_n = 1'b0;
                while (got < 40 && guard < 3000) begin
                    will = !empty;
                    @(negedge rd_clk);
                    guard++;
                    if (will) begin
                        check_val("R11 async data order", 32'(rd_data), 32'(pat(ri)));
                        ri++;
                        got++;
                    end
                end
                rd_en_n = 1'b1;
                check_val("R11 async word count", 32'(got), 32'd40);
            end
        join
        repeat (4) @(negedge aclk);
        check_val("R11 async empty after drain", 32'(empty), 32'h1);
        @(negedge clk);
        async_mode = 1'b0;
        settle();
        check_flags("R11 final", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule